// File: doc/BRIEF.md
# Parallel Polar Encoder, Length 16

This block encodes a 16-bit information vector into a 16-bit polar codeword in one pass through a fixed combinational network. The network is a cascade of four XOR butterfly stages. Each stage holds eight two-input kernel cells, and each cell turns a pair (a, b) into (a XOR b, b), which is the lower-triangular 2x2 kernel. The cells in stage s join the lines whose indices differ by 2^(s-1). The connection pattern is the same as a radix-2 FFT, with the kernel in place of each butterfly.

Bits enter in natural index order and leave in bit-reversed index order. One output register captures the codeword together with a valid flag, so a new word can be accepted on every clock. The block is also the arithmetic reference against which time-multiplexed versions of the encoder are compared.

Top module: `polar_enc_par`

## Requirements
- R1: A synchronous active-high reset clears `out_vld` and `out_word` to zero on the next rising edge, including while `in_vld` is high.
- R2: `out_vld` equals the `in_vld` sampled one clock earlier whenever reset was low at that earlier edge.
- R3: While `in_vld` is low, `out_word` keeps its value and ignores `in_word`.
- R4: Let u be `in_word`, where bit r is u_r. Define x_c as the XOR of all u_r whose index r satisfies (r AND c) == c. One clock after an accepted word, `out_word` bit k equals x at index bitrev4(k), where bitrev4 reverses the four index bits.
- R5: Output bit 0 equals the XOR of all 16 bits of the accepted word.
- R6: Output bit 15 equals input bit 15 of the accepted word.
- R7: The mapping is linear: the encoding of (a XOR b) equals the XOR of the encodings of a and of b.
- R8: An all-zero word encodes to zero. An all-one word encodes to a word in which only bit 15 is set.
- R9: Words presented on consecutive clocks are each encoded correctly, one result per clock.
- R10: A word with only input bit r set encodes to a word with exactly 2^popcount(r) bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Marks `in_word` as a word to encode |
| in_word | input | 16 | Information vector, natural index order |
| out_vld | output | 1 | Marks `out_word` as a fresh codeword |
| out_word | output | 16 | Codeword, bit-reversed index order |

## Verification
On every cycle the assertions check that reset clears the outputs, that valid follows the input one cycle later, and that the output holds while no word is offered. They also check two fixed corners of the transform: the parity bit at position 0 and the pass-through bit at position 15. Only the bench can show that the full transform and the bit-reversed output order are correct. It does this by sweeping all 65,536 words back to back against an arithmetic model, and it adds checks for linearity, output weight, the all-zero and all-one words, and a reset issued in the middle of the stream.

// File: rtl/polar_enc_pkg.sv
package polar_enc_pkg;

   // Reverse the lowest 'width' bits of an index.
   function automatic int unsigned bit_rev(input int unsigned idx, input int unsigned width);
      int unsigned r;
      r = 0;
      for (int unsigned i = 0; i < width; i++) begin
         r = (r << 1) | ((idx >> i) & 1);
      end
      return r;
   endfunction

   // Line pair joined by cell 'p' of a stage whose span is 'span'.
   function automatic int unsigned pair_lo(input int unsigned p, input int unsigned span);
      return (p / span) * 2 * span + (p % span);
   endfunction

endpackage

// File: rtl/polar_kernel_cell.sv
module polar_kernel_cell (
   input  logic a_in,
   input  logic b_in,
   output logic a_out,
   output logic b_out
);
   // Lower-triangular kernel: (a, b) -> (a ^ b, b)
   always_comb begin
      a_out = a_in ^ b_in;
      b_out = b_in;
   end
endmodule

// File: rtl/polar_xor_stage.sv
module polar_xor_stage #(
   parameter int N    = 16,
   parameter int SPAN = 1
) (
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   import polar_enc_pkg::*;

   localparam int CELLS = N / 2;

   if (SPAN < 1 || SPAN >= N || (SPAN & (SPAN - 1)) != 0) begin : g_bad_span
      $error("polar_xor_stage: SPAN must be a power of two below N");
   end

   for (genvar p = 0; p < CELLS; p++) begin : g_cell
      localparam int LO = int'(pair_lo(p, SPAN));
      localparam int HI = LO + SPAN;
      polar_kernel_cell i_cell (
         .a_in  (d[LO]),
         .b_in  (d[HI]),
         .a_out (q[LO]),
         .b_out (q[HI])
      );
   end
endmodule

// File: rtl/polar_bitrev_perm.sv
module polar_bitrev_perm #(
   parameter int LOG2N = 4
) (
   input  logic [(1<<LOG2N)-1:0] d,
   output logic [(1<<LOG2N)-1:0] q
);
   import polar_enc_pkg::*;

   localparam int N = 1 << LOG2N;

   for (genvar k = 0; k < N; k++) begin : g_wire
      localparam int SRC = int'(bit_rev(k, LOG2N));
      assign q[k] = d[SRC];
   end
endmodule

// File: rtl/polar_butterfly_net.sv
module polar_butterfly_net #(
   parameter int LOG2N = 4
) (
   input  logic [(1<<LOG2N)-1:0] u,
   output logic [(1<<LOG2N)-1:0] x
);
   localparam int N = 1 << LOG2N;

   logic [N-1:0] lvl [LOG2N+1];

   assign lvl[0] = u;

   for (genvar s = 0; s < LOG2N; s++) begin : g_stage
      polar_xor_stage #(
         .N    (N),
         .SPAN (1 << s)
      ) i_stage (
         .d (lvl[s]),
         .q (lvl[s+1])
      );
   end

   assign x = lvl[LOG2N];
endmodule

// File: rtl/polar_enc_par.sv
module polar_enc_par #(
   parameter int LOG2N = 4,
   parameter int N     = 1 << LOG2N
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_vld,
   input  logic [N-1:0] in_word,
   output logic         out_vld,
   output logic [N-1:0] out_word
);
   if (LOG2N < 1 || LOG2N > 12) begin : g_bad_log
      $error("polar_enc_par: LOG2N out of range 1..12");
   end
   if (N != (1 << LOG2N)) begin : g_bad_n
      $error("polar_enc_par: N must equal 2**LOG2N");
   end

   logic [N-1:0] nat_cw;
   logic [N-1:0] rev_cw;

   polar_butterfly_net #(.LOG2N(LOG2N)) i_net (
      .u (in_word),
      .x (nat_cw)
   );

   polar_bitrev_perm #(.LOG2N(LOG2N)) i_perm (
      .d (nat_cw),
      .q (rev_cw)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_vld  <= 1'b0;
         out_word <= '0;
      end else begin
         out_vld <= in_vld;
         if (in_vld) begin
            out_word <= rev_cw;
         end
      end
   end
endmodule

// File: rtl/polar_enc_par_chk.sv
module polar_enc_par_chk #(
   parameter int N = 16
) (
   input logic         clk,
   input logic         rst,
   input logic         in_vld,
   input logic [N-1:0] in_word,
   input logic         out_vld,
   input logic [N-1:0] out_word
);
   // R1: reset leaves both outputs cleared
   p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!out_vld && out_word == '0));

   // R2: valid follows input valid by one cycle
   p_valid_lat_r2: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (out_vld == $past(in_vld)));

   // R3: output held while no word is offered
   p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(in_vld)) |-> $stable(out_word));

   // R5: position 0 carries the parity of the whole word
   p_parity_bit_r5: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(in_vld)) |-> (out_word[0] == ^$past(in_word)));

   // R6: top position passes the top input bit through
   p_top_bit_r6: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(in_vld)) |-> (out_word[N-1] == $past(in_word[N-1])));
endmodule

bind polar_enc_par polar_enc_par_chk #(.N(N)) i_chk (
   .clk      (clk),
   .rst      (rst),
   .in_vld   (in_vld),
   .in_word  (in_word),
   .out_vld  (out_vld),
   .out_word (out_word)
);

// File: tb/test_polar_enc_par.sv
`timescale 1ns/1ps
module test_polar_enc_par;
   localparam int N = 16;
   localparam int LOGN = 4;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_vld = 1'b0;
   logic [N-1:0] in_word = '0;
   logic         out_vld;
   logic [N-1:0] out_word;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   polar_enc_par i_polar_enc_par (
      .clk      (clk),
      .rst      (rst),
      .in_vld   (in_vld),
      .in_word  (in_word),
      .out_vld  (out_vld),
      .out_word (out_word)
   );

   function automatic int rev4(input int k);
      int r = 0;
      for (int i = 0; i < LOGN; i++) r = (r << 1) | ((k >> i) & 1);
      return r;
   endfunction

   // Arithmetic model of R4
   function automatic logic [N-1:0] enc(input logic [N-1:0] u);
      logic [N-1:0] x;
      logic [N-1:0] o;
      for (int c = 0; c < N; c++) begin
         x[c] = 1'b0;
         for (int r = 0; r < N; r++)
            if ((r & c) == c) x[c] = x[c] ^ u[r];
      end
      for (int k = 0; k < N; k++) o[k] = x[rev4(k)];
      return o;
   endfunction

   task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Offer one word, return with its result visible
   task automatic apply(input logic [N-1:0] w);
      @(negedge clk);
      in_vld = 1'b1;
      in_word = w;
      @(negedge clk);
      in_vld = 1'b0;
   endtask

   initial begin
      logic [N-1:0] ea, eb, held;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 reset valid", {15'd0, out_vld}, '0);
      chk("R1 reset word", out_word, '0);

      // R9/R4/R2/R5/R6: exhaustive back-to-back sweep
      for (int w = 0; w <= 65536; w++) begin
         @(negedge clk);
         if (w > 0) begin
            logic [N-1:0] pw;
            pw = N'(w - 1);
            chk("R2 valid in stream", {15'd0, out_vld}, 16'd1);
            chk("R9 R4 codeword", out_word, enc(pw));
            chk("R5 parity bit", {15'd0, out_word[0]}, {15'd0, ^pw});
            chk("R6 top bit", {15'd0, out_word[N-1]}, {15'd0, pw[N-1]});
         end
         if (w < 65536) begin
            in_vld = 1'b1;
            in_word = N'(w);
         end else begin
            in_vld = 1'b0;
         end
      end

      // R8: corner words
      apply('0);
      chk("R8 zero word", out_word, '0);
      apply('1);
      chk("R8 ones word", out_word, 16'h8000);

      // R10: single-bit weights
      for (int r = 0; r < N; r++) begin
         apply(N'(1) << r);
         chk("R10 weight", N'($countones(out_word)), N'(1 << $countones(r)));
      end

      // R7: linearity
      for (int i = 0; i < 8; i++) begin
         logic [N-1:0] a, b;
         a = N'(16'h1357 * (i + 3));
         b = N'(16'hBEEF ^ (i * 16'h0F1D));
         apply(a); ea = out_word;
         apply(b); eb = out_word;
         apply(a ^ b);
         chk("R7 linearity", out_word, ea ^ eb);
      end

      // R3: idle cycles ignore in_word
      apply(16'hA5C3);
      held = out_word;
      chk("R4 before hold", held, enc(16'hA5C3));
      for (int i = 0; i < 3; i++) begin
         in_word = N'(16'h3C5A + i * 16'h1111);
         @(negedge clk);
         chk("R3 hold word", out_word, held);
         chk("R2 idle valid", {15'd0, out_vld}, '0);
      end

      // R1: reset while a word is offered
      @(negedge clk);
      in_vld = 1'b1;
      in_word = 16'hFFFF;
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      in_vld = 1'b0;
      chk("R1 mid reset valid", {15'd0, out_vld}, '0);
      chk("R1 mid reset word", out_word, '0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1900000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule